// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sets the power state of a small microcontroller core. Software asks for one of two low-power modes through level request bits. In idle the core clock stops and the peripheral clock keeps running. In power-down the oscillator enable drops, so every clock stops. Register and RAM contents are kept in both modes.

The two modes are left in different ways. An enabled interrupt or a hardware reset ends idle, but only a hardware reset ends power-down. The hardware reset input passes through a two-stage synchroniser. In power-down the clock has stopped, so the reset pin also drives the oscillator enable and the register-file reset directly. When a reset ends idle, the core keeps running for a fixed hand-off window of two machine cycles before the register reset takes over. RAM access is blocked during that window so that no stray write reaches memory. A reset never clears RAM.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: While rst_ni is low, sfr_rst_o is 1, all three clock enables are 1, and ram_inhibit_o and mode_clr_o are 0. On the first clock edge after release, with hw_rst_i low, the block enters the running state: clock enables all 1, and every other output 0.
- R2: A high idle_req_i in the running state makes cpu_clk_en_o 0 from the next clock edge on. per_clk_en_o and osc_en_o stay 1.
- R3: A high irq_pending_i in idle restores cpu_clk_en_o on the next edge. mode_clr_o is high for exactly that one cycle. Requests are not acted on while mode_clr_o is high.
- R4: A high pd_req_i in the running state makes cpu_clk_en_o, per_clk_en_o and osc_en_o all 0 from the next edge on.
- R5: If idle_req_i and pd_req_i are both high, power-down is entered.
- R6: irq_pending_i has no effect in power-down. All clock enables stay 0.
- R7: In power-down, a high hw_rst_i raises osc_en_o and sfr_rst_o at once, without any clock edge. On the third edge after hw_rst_i rises, the block is in the reset state: all clock enables 1 and sfr_rst_o 1.
- R8: Outside power-down, hw_rst_i acts through two synchroniser stages. sfr_rst_o rises on the third edge after hw_rst_i rises, and the block returns to the running state on the third edge after hw_rst_i falls.
- R9: A reset that ends idle first starts a hand-off window of HANDOFF_MC*CLKS_PER_MC cycles (24 by default), beginning on the third edge after hw_rst_i rises. During the window cpu_clk_en_o is 1, ram_inhibit_o is 1 and sfr_rst_o is 0. After the window sfr_rst_o is 1 and ram_inhibit_o is 0.
- R10: ram_inhibit_o is 1 only in the hand-off window. It is 0 in the running, idle, power-down and reset states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| idle_req_i | input | 1 | Software idle mode request bit |
| pd_req_i | input | 1 | Software power-down request bit |
| irq_pending_i | input | 1 | An enabled interrupt is pending |
| hw_rst_i | input | 1 | Hardware reset pin, active high |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| sfr_rst_o | output | 1 | Register-file reset |
| ram_inhibit_o | output | 1 | Blocks RAM access during the reset hand-off |
| mode_clr_o | output | 1 | One-cycle clear for the mode request bits |

## Verification
Latency differs by input:
- A software request or an interrupt shows at the outputs one edge after it is driven.
- A hardware reset shows on the third edge, after its two synchroniser stages.
- In power-down the reset pin acts on osc_en_o and sfr_rst_o within the same time step, with no edge at all.
- The hand-off window then adds 24 edges before the register reset.

The bench drives inputs on the falling edge and counts the exact number of rising edges each result needs. It samples once one edge before the change is due, to see the old value, and again on the edge where the change is due.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_PDOWN,
    ST_HANDOFF,
    ST_RESET
  } pwr_state_e;
endpackage

// File: rtl/sleep_rst_sync.sv
module sleep_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/sleep_win_cnt.sv
module sleep_win_cnt #(
  parameter int unsigned WIN_CYCLES = 24,
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES > 1 ? WIN_CYCLES : 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_req_i,
  input  logic       pd_req_i,
  input  logic       irq_pending_i,
  input  logic       rst_sync_i,
  input  logic       win_zero_i,
  output pwr_state_e state_o,
  output logic       win_load_o,
  output logic       mode_clr_o
);
  pwr_state_e state_q, state_d;
  logic       clr_q, clr_d;

  always_comb begin
    state_d    = state_q;
    clr_d      = 1'b0;
    win_load_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (rst_sync_i)      state_d = ST_RESET;
        else if (clr_q)      state_d = ST_RUN;   // request bits still being cleared
        else if (pd_req_i)   state_d = ST_PDOWN; // power-down wins
        else if (idle_req_i) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (rst_sync_i) begin
          state_d    = ST_HANDOFF;
          win_load_o = 1'b1;
        end else if (irq_pending_i) begin
          state_d = ST_RUN;
          clr_d   = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (rst_sync_i) state_d = ST_RESET;
      end
      ST_HANDOFF: begin
        if (win_zero_i) state_d = ST_RESET;
      end
      ST_RESET: begin
        if (!rst_sync_i) state_d = ST_RUN;
      end
      default: state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_RESET;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= clr_d;
    end

  assign state_o    = state_q;
  assign mode_clr_o = clr_q;
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLKS_PER_MC = 12,
  parameter int unsigned HANDOFF_MC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_req_i,
  input  logic pd_req_i,
  input  logic irq_pending_i,
  input  logic hw_rst_i,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic osc_en_o,
  output logic sfr_rst_o,
  output logic ram_inhibit_o,
  output logic mode_clr_o
);
  localparam int unsigned WIN_CYCLES = CLKS_PER_MC * HANDOFF_MC;

  logic       rst_sync;
  logic       win_load;
  logic       win_zero;
  pwr_state_e state;

  sleep_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (hw_rst_i),
    .sync_o  (rst_sync)
  );

  sleep_win_cnt #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (win_load),
    .dec_i  (state == ST_HANDOFF),
    .zero_o (win_zero)
  );

  sleep_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .idle_req_i    (idle_req_i),
    .pd_req_i      (pd_req_i),
    .irq_pending_i (irq_pending_i),
    .rst_sync_i    (rst_sync),
    .win_zero_i    (win_zero),
    .state_o       (state),
    .win_load_o    (win_load),
    .mode_clr_o    (mode_clr_o)
  );

  // in power-down the clock is stopped, so the pin must act directly
  assign osc_en_o      = (state != ST_PDOWN) | hw_rst_i;
  assign sfr_rst_o     = (state == ST_RESET) | ((state == ST_PDOWN) & hw_rst_i);
  assign per_clk_en_o  = (state != ST_PDOWN);
  assign cpu_clk_en_o  = (state == ST_RUN) | (state == ST_HANDOFF) | (state == ST_RESET);
  assign ram_inhibit_o = (state == ST_HANDOFF);
endmodule

// File: rtl/sleep_pwr_chk.sv
module sleep_pwr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hw_rst_i,
  input logic rst_sync_i,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic osc_en_o,
  input logic sfr_rst_o,
  input logic ram_inhibit_o,
  input logic mode_clr_o
);
  // R4: oscillator off implies every clock enable off
  a_r4_all_clocks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && !per_clk_en_o));

  // R9 / R10: RAM blocked only while core runs and before register reset
  a_r9_inhibit_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_inhibit_o |-> (cpu_clk_en_o && per_clk_en_o && !sfr_rst_o));

  // R3: clear is a single-cycle pulse
  a_r3_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_clr_o |=> !mode_clr_o);

  // R3: clear coincides with core clock return
  a_r3_clr_with_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_clr_o |-> $rose(cpu_clk_en_o));

  // R6: without a synchronised reset, power-down is not left
  a_r6_pd_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_clk_en_o && !rst_sync_i) |=> !per_clk_en_o);

  // R7: reset pin always keeps the oscillator running
  a_r7_osc_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_i |-> osc_en_o);
endmodule

bind sleep_pwr_ctrl sleep_pwr_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hw_rst_i      (hw_rst_i),
  .rst_sync_i    (rst_sync),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .per_clk_en_o  (per_clk_en_o),
  .osc_en_o      (osc_en_o),
  .sfr_rst_o     (sfr_rst_o),
  .ram_inhibit_o (ram_inhibit_o),
  .mode_clr_o    (mode_clr_o)
);

// File: tb/sleep_pwr_ctrl_tb_top.sv
module sleep_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 24;

  logic clk_i = 1'b0;
  logic rst_ni, idle_req_i, pd_req_i, irq_pending_i, hw_rst_i;
  logic cpu_clk_en_o, per_clk_en_o, osc_en_o, sfr_rst_o, ram_inhibit_o, mode_clr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sleep_pwr_ctrl dut_i (
    .clk_i, .rst_ni, .idle_req_i, .pd_req_i, .irq_pending_i, .hw_rst_i,
    .cpu_clk_en_o, .per_clk_en_o, .osc_en_o, .sfr_rst_o, .ram_inhibit_o, .mode_clr_o
  );

  // output vector {cpu, per, osc, sfr, ram, clr}
  function automatic logic [5:0] outs();
    return {cpu_clk_en_o, per_clk_en_o, osc_en_o, sfr_rst_o, ram_inhibit_o, mode_clr_o};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // {idle, pd, irq, req-id, expected outputs}; applied at negedge, checked one edge later
  typedef struct packed {
    logic       idle;
    logic       pd;
    logic       irq;
    logic [3:0] req;
    logic [5:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 1'b0, 4'd2, 6'b011000}, // R2 enter idle
    '{1'b1, 1'b0, 1'b0, 4'd2, 6'b011000}, // R2 stay idle
    '{1'b1, 1'b0, 1'b1, 4'd3, 6'b111001}, // R3 interrupt wakes, clear pulse
    '{1'b0, 1'b0, 1'b0, 4'd3, 6'b111000}, // R3 pulse ends
    '{1'b1, 1'b1, 1'b0, 4'd5, 6'b000000}, // R5 power-down wins, R4 clocks off
    '{1'b0, 1'b1, 1'b1, 4'd6, 6'b000000}, // R6 interrupt ignored
    '{1'b0, 1'b0, 1'b0, 4'd6, 6'b000000}  // R6 still down
  };

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; idle_req_i = 1'b0; pd_req_i = 1'b0; irq_pending_i = 1'b0; hw_rst_i = 1'b0;
    step(2);
    check("R1 reset state", 6'b111100);
    rst_ni = 1'b1;
    step(1);
    check("R1 running after release", 6'b111000);

    foreach (VECS[i]) begin
      idle_req_i = VECS[i].idle; pd_req_i = VECS[i].pd; irq_pending_i = VECS[i].irq;
      step(1);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R7: asynchronous exit from power-down
    hw_rst_i = 1'b1;
    #1;
    check("R7 immediate osc and reset", 6'b001100);
    @(negedge clk_i);
    step(1);
    check("R7 before sync", 6'b001100);
    step(1);
    check("R7 reset state", 6'b111100);
    hw_rst_i = 1'b0;
    step(2);
    check("R8 release pending", 6'b111100);
    step(1);
    check("R8 running after release", 6'b111000);

    // R8 / R10: reset from running goes straight to reset, RAM never blocked
    hw_rst_i = 1'b1;
    step(2);
    check("R8 before sync", 6'b111000);
    step(1);
    check("R8 R10 reset without inhibit", 6'b111100);
    hw_rst_i = 1'b0;
    step(3);
    check("R8 back to running", 6'b111000);

    // R9: idle ended by reset, hand-off window
    idle_req_i = 1'b1;
    step(1);
    check("R2 idle before reset", 6'b011000);
    hw_rst_i = 1'b1;
    step(2);
    check("R9 still idle", 6'b011000);
    step(1);
    check("R9 handoff start", 6'b111010);
    step(WIN - 1);
    check("R9 handoff last cycle", 6'b111010);
    step(1);
    check("R9 R10 register reset after window", 6'b111100);
    idle_req_i = 1'b0;
    hw_rst_i   = 1'b0;
    step(3);
    check("R8 running after handoff reset", 6'b111000);

    // R3: interrupt in running state changes nothing
    irq_pending_i = 1'b1;
    step(1);
    check("R3 irq while running", 6'b111000);
    irq_pending_i = 1'b0;

    // R1: power-on reset from power-down
    pd_req_i = 1'b1;
    step(1);
    check("R4 power-down entry", 6'b000000);
    rst_ni = 1'b0;
    #1;
    check("R1 reset overrides power-down", 6'b111100);
    pd_req_i = 1'b0;
    rst_ni   = 1'b1;
    step(1);
    check("R1 running after second release", 6'b111000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule